// File: doc/BRIEF.md
# CORDIC similarity vector rotator

This block turns a two-dimensional fixed-point vector (x, y) through an angle a. Every stage is unrolled and pipelined, so the block accepts one new vector on each enabled clock. The result is not normalised. Both output coordinates keep the CORDIC gain K ≈ 1.646760258121, so the block computes x0 = K(x·cos a − y·sin a) and y0 = K(x·sin a + y·cos a). Logic downstream that needs a pure rotation must remove K itself, or fold it into a later coefficient.

A parameter chooses how the coordinates are read. In signed mode they are two's complement values in [−1, +1] and the angle spans [−π, +π]. In unsigned mode the coordinates lie in [0, 1] and the angle in [0, π]. The angle carries as many fraction bits as the coordinates. An angle whose magnitude exceeds π/2 first gets a quarter-turn pre-rotation. A chain of micro-rotations follows, each steered by the sign of the angle that remains. A final stage rounds the results to the output fraction width.

A valid flag travels with the data. An optional enable input freezes the whole pipeline.

Top module: `cordic_sim_rotator`

## Requirements
- R1: For any angle within ±π/2, each output matches K(x·cos a − y·sin a) and K(x·sin a + y·cos a) within 2 output LSBs, where K = 1.646760258121.
- R2: For angles of magnitude between π/2 and π, including ±π, R1's formulas and tolerance still hold.
- R3: Both outputs are two's complement with FRAC_OUT+3 bits, of which FRAC_OUT are fraction bits. They are rounded to nearest from the internal precision.
- R4: With SIGNED_IN=0, x, y and the angle are read as unsigned (x, y in [0,1], angle in [0,π]). The outputs stay signed and follow R1's formulas and tolerance.
- R5: While the enable is low, no register changes: out_valid_o, x_o and y_o hold their values. An input presented with in_valid_i high during that time is not accepted and never produces a result.
- R6: A vector accepted on an enabled clock edge appears with out_valid_o high after exactly STAGES+2 enabled edges, counting its capture edge, where STAGES = FRAC_IN+2. Back-to-back inputs give back-to-back results in order, one per input.
- R7: A synchronous active-high reset clears out_valid_o, x_o and y_o to zero on the next edge. Reset takes priority over the enable.
- R8: x_i and y_i are FRAC_IN+2 bits wide and ang_i is FRAC_IN+3 bits wide. All three carry FRAC_IN fraction bits, with the angle in radians.
- R9: Full-scale corner vectors such as (1,1) or (−1,−1) at ±π/4 produce magnitudes up to K·√2 without wrapping. R1's tolerance holds, and no output exceeds ±2.4 in magnitude.
- R10: With ENABLE_PORT=0, en_i is ignored and the pipeline advances on every clock, even when en_i is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Pipeline enable; low freezes all stages (ignored when ENABLE_PORT=0) |
| in_valid_i | input | 1 | Marks x_i, y_i, ang_i as a vector to rotate |
| x_i | input | FRAC_IN+2 | Input x coordinate, FRAC_IN fraction bits |
| y_i | input | FRAC_IN+2 | Input y coordinate, FRAC_IN fraction bits |
| ang_i | input | FRAC_IN+3 | Rotation angle in radians, FRAC_IN fraction bits |
| out_valid_o | output | 1 | Marks x_o, y_o as a fresh result |
| x_o | output | FRAC_OUT+3 | Rotated, K-scaled x, signed, FRAC_OUT fraction bits |
| y_o | output | FRAC_OUT+3 | Rotated, K-scaled y, signed, FRAC_OUT fraction bits |

## Verification
Each fault in the internal state has its own signature at the outputs, and it shows up STAGES+2 enabled cycles after the affected input.

- **Wrong arctangent constant or stage direction:** the result is turned by a wrong residual angle. The error grows with the vector's length, so the full-scale vectors near ±π/4 expose it best.
- **Faulty quarter-turn pre-rotation:** only angles beyond ±π/2 are affected. Their results come out mirrored or swapped.
- **Broken valid chain:** results go missing or appear with no matching input, and the in-order expectations stop lining up.
- **Enable that leaks into any register:** the held outputs change within one clock of the stall starting, or an input offered during the stall comes back out.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    // Quarter-turn choice made ahead of the micro-rotation chain
    typedef enum logic [1:0] {
        PRE_NONE = 2'd0,
        PRE_POS  = 2'd1,
        PRE_NEG  = 2'd2
    } prerot_e;

    // Micro-rotation direction derived from the remaining angle
    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } rot_dir_e;

    // Number of micro-rotation stages for a given input fraction width
    function automatic int stage_count(input int frac_in);
        return frac_in + 2;
    endfunction

    // atan(2^-idx) as a fixed-point value with frac fraction bits
    function automatic int atan_fix(input int idx, input int frac);
        real t;
        t = $atan(1.0 / (2.0 ** idx));
        return $rtoi(t * (2.0 ** frac) + 0.5);
    endfunction

    // pi/2 as a fixed-point value with frac fraction bits
    function automatic int halfpi_fix(input int frac);
        return $rtoi(1.5707963267948966 * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot #(
    parameter int IN_W      = 16,
    parameter int ANG_W     = 17,
    parameter int IW        = 21,
    parameter int GUARD     = 3,
    parameter int IFRAC     = 17,
    parameter bit SIGNED_IN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 vld_i,
    input  logic [IN_W-1:0]      x_i,
    input  logic [IN_W-1:0]      y_i,
    input  logic [ANG_W-1:0]     a_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    import cordic_rot_pkg::*;

    localparam int XPAD = IW - IN_W - GUARD;
    localparam int APAD = IW - ANG_W - GUARD;
    localparam logic signed [IW-1:0] HALF = IW'(halfpi_fix(IFRAC));

    logic                 x_ext, y_ext, a_ext;
    logic signed [IW-1:0] xe, ye, ze;
    logic signed [IW-1:0] xn, yn, zn;
    prerot_e              sel;

    always_comb begin
        x_ext = SIGNED_IN ? x_i[IN_W-1]  : 1'b0;
        y_ext = SIGNED_IN ? y_i[IN_W-1]  : 1'b0;
        a_ext = SIGNED_IN ? a_i[ANG_W-1] : 1'b0;
        xe = {{XPAD{x_ext}}, x_i, {GUARD{1'b0}}};
        ye = {{XPAD{y_ext}}, y_i, {GUARD{1'b0}}};
        ze = {{APAD{a_ext}}, a_i, {GUARD{1'b0}}};

        if (ze > HALF)
            sel = PRE_POS;
        else if (ze < -HALF)
            sel = PRE_NEG;
        else
            sel = PRE_NONE;

        case (sel)
            PRE_POS: begin
                xn = -ye;
                yn = xe;
                zn = ze - HALF;
            end
            PRE_NEG: begin
                xn = ye;
                yn = -xe;
                zn = ze + HALF;
            end
            default: begin
                xn = xe;
                yn = ye;
                zn = ze;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            x_o   <= '0;
            y_o   <= '0;
            z_o   <= '0;
        end else if (en) begin
            vld_o <= vld_i;
            x_o   <= xn;
            y_o   <= yn;
            z_o   <= zn;
        end
    end

endmodule

// File: rtl/cordic_microstage.sv
module cordic_microstage #(
    parameter int IW    = 21,
    parameter int IFRAC = 17,
    parameter int IDX   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [IW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    import cordic_rot_pkg::*;

    localparam logic signed [IW-1:0] ATAN_C = IW'(atan_fix(IDX, IFRAC));

    rot_dir_e             dir;
    logic signed [IW-1:0] xs, ys;
    logic signed [IW-1:0] xn, yn, zn;

    always_comb begin
        dir = z_i[IW-1] ? DIR_CW : DIR_CCW;
        xs  = x_i >>> IDX;
        ys  = y_i >>> IDX;
        if (dir == DIR_CCW) begin
            xn = x_i - ys;
            yn = y_i + xs;
            zn = z_i - ATAN_C;
        end else begin
            xn = x_i + ys;
            yn = y_i - xs;
            zn = z_i + ATAN_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            x_o   <= '0;
            y_o   <= '0;
            z_o   <= '0;
        end else if (en) begin
            vld_o <= vld_i;
            x_o   <= xn;
            y_o   <= yn;
            z_o   <= zn;
        end
    end

endmodule

// File: rtl/cordic_round_out.sv
module cordic_round_out #(
    parameter int IW    = 21,
    parameter int SH    = 5,
    parameter int OUT_W = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    output logic                 vld_o,
    output logic [OUT_W-1:0]     x_o,
    output logic [OUT_W-1:0]     y_o
);
    localparam logic signed [IW-1:0] HALF_LSB = IW'(1) <<< (SH - 1);

    logic signed [IW-1:0] xr, yr;

    always_comb begin
        xr = x_i + HALF_LSB;
        yr = y_i + HALF_LSB;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            x_o   <= '0;
            y_o   <= '0;
        end else if (en) begin
            vld_o <= vld_i;
            x_o   <= xr[SH +: OUT_W];
            y_o   <= yr[SH +: OUT_W];
        end
    end

endmodule

// File: rtl/cordic_sim_rotator.sv
module cordic_sim_rotator #(
    parameter int FRAC_IN     = 14,
    parameter int FRAC_OUT    = 12,
    parameter bit SIGNED_IN   = 1'b1,
    parameter bit ENABLE_PORT = 1'b1,
    parameter int GUARD       = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  in_valid_i,
    input  logic [FRAC_IN+1:0]    x_i,
    input  logic [FRAC_IN+1:0]    y_i,
    input  logic [FRAC_IN+2:0]    ang_i,
    output logic                  out_valid_o,
    output logic [FRAC_OUT+2:0]   x_o,
    output logic [FRAC_OUT+2:0]   y_o
);
    import cordic_rot_pkg::*;

    localparam int IN_W   = FRAC_IN + 2;
    localparam int ANG_W  = FRAC_IN + 3;
    localparam int OUT_W  = FRAC_OUT + 3;
    localparam int STAGES = stage_count(FRAC_IN);
    localparam int IFRAC  = FRAC_IN + GUARD;
    localparam int IW     = IFRAC + 4;
    localparam int SH     = IFRAC - FRAC_OUT;

    logic en_eff;

    generate
        if (ENABLE_PORT) begin : g_en
            assign en_eff = en_i;
        end else begin : g_noen
            assign en_eff = 1'b1;
        end
    endgenerate

    logic                 pv [STAGES+1];
    logic signed [IW-1:0] px [STAGES+1];
    logic signed [IW-1:0] py [STAGES+1];
    logic signed [IW-1:0] pz [STAGES+1];

    cordic_prerot #(
        .IN_W      (IN_W),
        .ANG_W     (ANG_W),
        .IW        (IW),
        .GUARD     (GUARD),
        .IFRAC     (IFRAC),
        .SIGNED_IN (SIGNED_IN)
    ) u_prerot (
        .clk   (clk),
        .rst   (rst),
        .en    (en_eff),
        .vld_i (in_valid_i),
        .x_i   (x_i),
        .y_i   (y_i),
        .a_i   (ang_i),
        .vld_o (pv[0]),
        .x_o   (px[0]),
        .y_o   (py[0]),
        .z_o   (pz[0])
    );

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            cordic_microstage #(
                .IW    (IW),
                .IFRAC (IFRAC),
                .IDX   (g)
            ) u_stage (
                .clk   (clk),
                .rst   (rst),
                .en    (en_eff),
                .vld_i (pv[g]),
                .x_i   (px[g]),
                .y_i   (py[g]),
                .z_i   (pz[g]),
                .vld_o (pv[g+1]),
                .x_o   (px[g+1]),
                .y_o   (py[g+1]),
                .z_o   (pz[g+1])
            );
        end
    endgenerate

    cordic_round_out #(
        .IW    (IW),
        .SH    (SH),
        .OUT_W (OUT_W)
    ) u_round (
        .clk   (clk),
        .rst   (rst),
        .en    (en_eff),
        .vld_i (pv[STAGES]),
        .x_i   (px[STAGES]),
        .y_i   (py[STAGES]),
        .vld_o (out_valid_o),
        .x_o   (x_o),
        .y_o   (y_o)
    );

endmodule

// File: rtl/cordic_sim_rotator_chk.sv
module cordic_sim_rotator_chk #(
    parameter int FRAC_IN     = 14,
    parameter int FRAC_OUT    = 12,
    parameter bit ENABLE_PORT = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                en_i,
    input logic                in_valid_i,
    input logic                out_valid_o,
    input logic [FRAC_OUT+2:0] x_o,
    input logic [FRAC_OUT+2:0] y_o
);
    localparam int DEPTH = FRAC_IN + 4;
    localparam int CW    = $clog2(DEPTH + 2) + 1;
    localparam int LIM   = $rtoi(2.4 * (2.0 ** FRAC_OUT));

    logic          en_eff;
    logic [CW-1:0] inflight;

    assign en_eff = ENABLE_PORT ? en_i : 1'b1;

    // accepted-minus-delivered count of vectors held in the pipeline
    always_ff @(posedge clk) begin
        if (rst)
            inflight <= '0;
        else if (en_eff)
            inflight <= inflight + CW'(in_valid_i) - CW'(out_valid_o);
    end

    // R7: reset empties the output register
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid_o && x_o == '0 && y_o == '0));

    // R5: a stalled clock leaves every output untouched
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        !en_eff |=> ($stable(out_valid_o) && $stable(x_o) && $stable(y_o)));

    // R6: never more vectors in flight than pipeline registers
    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(DEPTH));

    // R6: every result traces back to an accepted input
    a_r6_valid_has_source: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> inflight != '0);

    // R9: scaled magnitude stays inside K*sqrt(2) margin, no wrap
    a_r9_mag_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> ($signed(x_o) <= LIM && $signed(x_o) >= -LIM &&
                         $signed(y_o) <= LIM && $signed(y_o) >= -LIM));

endmodule

bind cordic_sim_rotator cordic_sim_rotator_chk #(
    .FRAC_IN     (FRAC_IN),
    .FRAC_OUT    (FRAC_OUT),
    .ENABLE_PORT (ENABLE_PORT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .x_o         (x_o),
    .y_o         (y_o)
);

// File: tb/cordic_sim_rotator_test.sv
module cordic_sim_rotator_test;

    localparam int FI    = 14;
    localparam int FO    = 12;
    localparam int IN_W  = FI + 2;
    localparam int ANG_W = FI + 3;
    localparam int OUT_W = FO + 3;
    localparam int STG   = FI + 2;
    localparam int LAT   = STG + 2;
    localparam real KG   = 1.646760258121;
    localparam real PI   = 3.14159265358979;
    localparam real SC_IN  = 2.0 ** FI;
    localparam real SC_OUT = 2.0 ** FO;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // signed instance
    logic             en_s = 1'b1;
    logic             s_valid = 1'b0;
    logic [IN_W-1:0]  s_x = '0, s_y = '0;
    logic [ANG_W-1:0] s_a = '0;
    logic             s_ov;
    logic [OUT_W-1:0] s_xo, s_yo;

    // unsigned instance, enable port disabled
    logic             en_u = 1'b0;
    logic             u_valid = 1'b0;
    logic [IN_W-1:0]  u_x = '0, u_y = '0;
    logic [ANG_W-1:0] u_a = '0;
    logic             u_ov;
    logic [OUT_W-1:0] u_xo, u_yo;

    cordic_sim_rotator #(
        .FRAC_IN(FI), .FRAC_OUT(FO), .SIGNED_IN(1'b1), .ENABLE_PORT(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .en_i(en_s), .in_valid_i(s_valid),
        .x_i(s_x), .y_i(s_y), .ang_i(s_a),
        .out_valid_o(s_ov), .x_o(s_xo), .y_o(s_yo)
    );

    cordic_sim_rotator #(
        .FRAC_IN(FI), .FRAC_OUT(FO), .SIGNED_IN(1'b0), .ENABLE_PORT(1'b0)
    ) uut_uns (
        .clk(clk), .rst(rst), .en_i(en_u), .in_valid_i(u_valid),
        .x_i(u_x), .y_i(u_y), .ang_i(u_a),
        .out_valid_o(u_ov), .x_o(u_xo), .y_o(u_yo)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    qsx[$], qsy[$];
    string qsr[$];
    int    qux[$], quy[$];
    string qur[$];

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    task automatic check_val(input string rq, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // driver: called at a falling edge, presents one vector for one enabled edge
    task automatic send_s(input real x, input real y, input real a, input string rq);
        int cx, cy, ca;
        real xq, yq, aq;
        cx = rnd(x * SC_IN); cy = rnd(y * SC_IN); ca = rnd(a * SC_IN);
        xq = cx / SC_IN; yq = cy / SC_IN; aq = ca / SC_IN;
        qsx.push_back(rnd(KG * (xq * $cos(aq) - yq * $sin(aq)) * SC_OUT));
        qsy.push_back(rnd(KG * (xq * $sin(aq) + yq * $cos(aq)) * SC_OUT));
        qsr.push_back(rq);
        s_x = cx[IN_W-1:0]; s_y = cy[IN_W-1:0]; s_a = ca[ANG_W-1:0];
        s_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic send_u(input real x, input real y, input real a, input string rq);
        int cx, cy, ca;
        real xq, yq, aq;
        cx = rnd(x * SC_IN); cy = rnd(y * SC_IN); ca = rnd(a * SC_IN);
        xq = cx / SC_IN; yq = cy / SC_IN; aq = ca / SC_IN;
        qux.push_back(rnd(KG * (xq * $cos(aq) - yq * $sin(aq)) * SC_OUT));
        quy.push_back(rnd(KG * (xq * $sin(aq) + yq * $cos(aq)) * SC_OUT));
        qur.push_back(rq);
        u_x = cx[IN_W-1:0]; u_y = cy[IN_W-1:0]; u_a = ca[ANG_W-1:0];
        u_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        u_valid = 1'b0;
    endtask

    // the enable seen at the last rising edge decides whether the output is new
    logic last_en = 1'b0;
    always @(posedge clk) last_en <= en_s;

    // monitors: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst && s_ov && last_en) begin
            if (qsx.size() == 0) begin
                check_val("R6 unexpected signed result", 1, 0, 0);
            end else begin
                string rq;
                int ex, ey;
                ex = qsx.pop_front(); ey = qsy.pop_front(); rq = qsr.pop_front();
                check_val({rq, " x"}, int'($signed(s_xo)), ex, 2);
                check_val({rq, " y"}, int'($signed(s_yo)), ey, 2);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && u_ov) begin
            if (qux.size() == 0) begin
                check_val("R10 unexpected unsigned result", 1, 0, 0);
            end else begin
                string rq;
                int ex, ey;
                ex = qux.pop_front(); ey = quy.pop_front(); rq = qur.pop_front();
                check_val({rq, " x"}, int'($signed(u_xo)), ex, 2);
                check_val({rq, " y"}, int'($signed(u_yo)), ey, 2);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [OUT_W-1:0] hx, hy;
        logic hv;

        repeat (5) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check_val("R7 reset valid", int'(s_ov), 0, 0);
        check_val("R7 reset x", int'(s_xo), 0, 0);
        check_val("R7 reset y", int'(u_yo), 0, 0);
        rst = 1'b0;
        @(negedge clk);

        // R3: output format width
        check_val("R3 output width", $bits(s_xo), FO + 3, 0);

        // R6: latency of a single vector
        begin
            int cx;
            cx = rnd(0.5 * SC_IN);
            qsx.push_back(rnd(KG * 0.5 * SC_OUT)); qsy.push_back(0); qsr.push_back("R6 latency vector");
            s_x = cx[IN_W-1:0]; s_y = '0; s_a = '0; s_valid = 1'b1;
            lat = 0;
            do begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                if (lat == 1) s_valid = 1'b0;
            end while (!s_ov && lat < 100);
            check_val("R6 latency cycles", lat, LAT, 0);
        end
        repeat (3) @(negedge clk);

        // R1, R8: angles within +-pi/2, signed two's complement inputs
        send_s(0.5, 0.25, 0.3, "R1 basic");
        send_s(-0.7, 0.4, -1.2, "R8 negative operands");
        send_s(1.0, 0.0, 0.0, "R1 unit x zero angle");
        send_s(0.0, 0.0, 1.0, "R1 zero vector");
        send_s(-0.3, -0.8, 1.5, "R1 near quarter turn");
        // R2: pre-rotated angles
        send_s(0.6, -0.3, 2.5, "R2 positive obtuse");
        send_s(0.2, 0.9, -2.8, "R2 negative obtuse");
        send_s(1.0, 0.0, PI, "R2 plus pi");
        send_s(0.5, 0.5, -PI, "R2 minus pi");
        // R9: full-scale corners
        send_s(1.0, 1.0, PI / 4.0, "R9 corner pos");
        send_s(-1.0, -1.0, PI / 4.0, "R9 corner neg");
        send_s(1.0, -1.0, -PI / 4.0, "R9 corner mixed");
        repeat (LAT + 2) @(negedge clk);
        check_val("R6 signed queue drained", qsx.size(), 0, 0);

        // R5: stall with results in flight and an offered input
        send_s(0.4, 0.1, 0.7, "R5 stall item0");
        send_s(-0.2, 0.6, -0.4, "R5 stall item1");
        send_s(0.9, -0.1, 2.0, "R5 stall item2");
        send_s(0.1, 0.1, -2.2, "R5 stall item3");
        while (!s_ov) @(negedge clk);
        en_s = 1'b0;
        hx = s_xo; hy = s_yo; hv = s_ov;
        s_x = 16'h1234; s_y = 16'h0F00; s_a = 17'h00400; s_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_val("R5 held x", int'(s_xo), int'(hx), 0);
            check_val("R5 held y", int'(s_yo), int'(hy), 0);
            check_val("R5 held valid", int'(s_ov), int'(hv), 0);
        end
        s_valid = 1'b0;
        en_s = 1'b1;
        repeat (LAT + 4) @(negedge clk);
        check_val("R5 no extra result from stalled input", qsx.size(), 0, 0);

        // R4, R10: unsigned instance, its enable held low
        send_u(0.9, 0.8, 3.0, "R4 unsigned obtuse");
        send_u(1.0, 1.0, 0.1, "R4 unsigned full scale");
        send_u(0.3, 0.0, 1.4, "R10 runs with enable low");
        send_u(0.5, 0.2, PI, "R4 unsigned pi");
        repeat (LAT + 4) @(negedge clk);
        check_val("R10 unsigned queue drained", qux.size(), 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule